// File: doc/BRIEF.md
# Calendar Alarm Comparator with Sticky Interrupt

This block watches the running time of day and raises an alarm when the programmed minute, hour and day settings agree with it. The day setting has two meanings, chosen by one mode input. In weekday mode it is a mask with one bit per weekday, so a single alarm can cover several days. In date mode it is a BCD day of the month. Bit 7 of any alarm setting removes that field from the comparison, so that field always counts as a match.

The comparison is made only on the cycle where the time base signals a minute rollover. A match therefore yields exactly one event per minute. An event sets a sticky alarm flag that stays set until the host clears it. If the interrupt enable is set, the flag also pulls an active-low, open-drain style request line low. The line is released (held at 1) when the flag is clear or the enable is off. The time counters, the host bus and the merging with other interrupt sources are outside this block.

Top module: `rtc_alarm_irq`

## Requirements
- R1: After reset, flag_o is 0 and irq_n_o is 1 (released).
- R2: In date mode (day_mode_i=1), a cycle with min_tick_i=1 sets flag_o on the next clock edge when the values agree. Minute is compared on bits 6:0, hour on bits 5:0 and date on bits 5:0.
- R3: In weekday mode (day_mode_i=0), cur_wday_i is one-hot with bit n standing for weekday n. The day field matches when any of alm_day_i bits 6:0 is set at the same position as the current weekday bit. An all-zero mask never matches.
- R4: When bit 7 of alm_min_i, alm_hour_i or alm_day_i is 1, that field always matches, whatever its other bits hold.
- R5: No event occurs in a cycle with min_tick_i=0, even if every field matches.
- R6: A mismatch in any one enabled field blocks the event, and flag_o stays 0.
- R7: Once set, flag_o stays 1 until a cycle with flag_clr_i=1. It is then 0 after that edge. If an event and a clear fall in the same cycle, the event wins and the flag stays 1.
- R8: After the edge that sets the flag, irq_n_o is 0 if irq_en_i=1. If irq_en_i=0, irq_n_o stays 1 while flag_o still sets.
- R9: irq_n_o returns to 1 one edge after irq_en_i falls or the flag is cleared. If irq_en_i is raised again while flag_o=1, irq_n_o goes to 0 after the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| min_tick_i | input | 1 | One-cycle strobe on a minute rollover; the time fields already hold the new minute |
| cur_min_i | input | 8 | Current minute, BCD |
| cur_hour_i | input | 8 | Current hour, BCD, 24-hour |
| cur_wday_i | input | 7 | Current weekday, one-hot |
| cur_mday_i | input | 8 | Current day of month, BCD |
| alm_min_i | input | 8 | Alarm minute; bit 7 disables the field |
| alm_hour_i | input | 8 | Alarm hour; bit 7 disables the field |
| alm_day_i | input | 8 | Alarm weekday mask or date; bit 7 disables the field |
| day_mode_i | input | 1 | 1 selects the date compare, 0 selects the weekday mask |
| irq_en_i | input | 1 | Interrupt enable |
| flag_clr_i | input | 1 | Host write of 0 to the flag |
| flag_o | output | 1 | Sticky alarm flag |
| irq_n_o | output | 1 | Interrupt request, active low; 1 means released |

## Verification
A wrong match decision shows up on flag_o at the first clock edge after a minute tick. A wrongly read mask bit, BCD width or disable bit gives a flag that differs from a vector's expected value in that same cycle. Faults in the flag register show one edge after the stimulus. A lost hold, a failed clear or the wrong priority between set and clear appear this way. Faults in the request line also show one edge after the stimulus: a request that stays low after the enable drops, or that ignores the enable.

// File: rtl/alarm_pkg.sv
package alarm_pkg;
  localparam int FIELD_W  = 8;
  localparam int WDAY_W   = 7;
  localparam int DIS_BIT  = FIELD_W - 1;
  localparam int MIN_VW   = 7;
  localparam int HOUR_VW  = 6;
  localparam int MDAY_VW  = 6;
endpackage

// File: rtl/alarm_field_cmp.sv
module alarm_field_cmp #(
  parameter int W     = 8,
  parameter int VAL_W = 7
) (
  input  logic [W-1:0] alm_i,
  input  logic [W-1:0] cur_i,
  output logic         hit_o
);
  localparam logic [W-1:0] VAL_MASK = W'((1 << VAL_W) - 1);

  // top bit of the alarm field disables the compare
  assign hit_o = alm_i[W-1] | (((alm_i ^ cur_i) & VAL_MASK) == '0);
endmodule

// File: rtl/alarm_day_cmp.sv
module alarm_day_cmp #(
  parameter int W      = 8,
  parameter int WDAY_W = 7,
  parameter int VAL_W  = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              day_mode_i,
  input  logic [W-1:0]      alm_i,
  input  logic [W-1:0]      cur_mday_i,
  input  logic [WDAY_W-1:0] cur_wday_i,
  output logic              hit_o
);
  localparam logic [W-1:0] VAL_MASK = W'((1 << VAL_W) - 1);

  logic date_hit, wday_hit;

  assign date_hit = ((alm_i ^ cur_mday_i) & VAL_MASK) == '0;
  assign wday_hit = |(alm_i[WDAY_W-1:0] & cur_wday_i);
  assign hit_o    = alm_i[W-1] | (day_mode_i ? date_hit : wday_hit);

  // R3
  empty_mask_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!day_mode_i && alm_i == '0) |-> !hit_o);
endmodule

// File: rtl/alarm_flag_ctl.sv
module alarm_flag_ctl (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic match_i,
  input  logic irq_en_i,
  input  logic clr_i,
  output logic flag_o,
  output logic irq_n_o
);
  logic flag_q, flag_d, irq_low_q, evt;

  assign evt    = tick_i & match_i;
  // a new event outranks a host clear in the same cycle
  assign flag_d = evt | (flag_q & ~clr_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flag_q    <= 1'b0;
      irq_low_q <= 1'b0;
    end else begin
      flag_q    <= flag_d;
      irq_low_q <= flag_d & irq_en_i;
    end
  end

  assign flag_o  = flag_q;
  assign irq_n_o = ~irq_low_q;

  // R2
  event_sets_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && match_i) |=> flag_o);
  // R5
  no_tick_no_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!flag_o && !tick_i) |=> !flag_o);
  // R7
  sticky_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_o && !clr_i) |=> flag_o);
  // R7
  clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && !(tick_i && match_i)) |=> !flag_o);
  // R9
  release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !irq_en_i |=> irq_n_o);
  // R9
  reassert_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_o && irq_en_i && !clr_i) |=> !irq_n_o);
endmodule

// File: rtl/rtc_alarm_irq.sv
module rtc_alarm_irq
  import alarm_pkg::*;
#(
  parameter int FW = FIELD_W,
  parameter int WW = WDAY_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          min_tick_i,
  input  logic [FW-1:0] cur_min_i,
  input  logic [FW-1:0] cur_hour_i,
  input  logic [WW-1:0] cur_wday_i,
  input  logic [FW-1:0] cur_mday_i,
  input  logic [FW-1:0] alm_min_i,
  input  logic [FW-1:0] alm_hour_i,
  input  logic [FW-1:0] alm_day_i,
  input  logic          day_mode_i,
  input  logic          irq_en_i,
  input  logic          flag_clr_i,
  output logic          flag_o,
  output logic          irq_n_o
);
  logic min_hit, hour_hit, day_hit, all_hit;

  alarm_field_cmp #(.W(FW), .VAL_W(MIN_VW)) u_min_cmp (
    .alm_i(alm_min_i), .cur_i(cur_min_i), .hit_o(min_hit));

  alarm_field_cmp #(.W(FW), .VAL_W(HOUR_VW)) u_hour_cmp (
    .alm_i(alm_hour_i), .cur_i(cur_hour_i), .hit_o(hour_hit));

  alarm_day_cmp #(.W(FW), .WDAY_W(WW), .VAL_W(MDAY_VW)) u_day_cmp (
    .clk_i(clk_i), .rst_ni(rst_ni), .day_mode_i(day_mode_i),
    .alm_i(alm_day_i), .cur_mday_i(cur_mday_i), .cur_wday_i(cur_wday_i),
    .hit_o(day_hit));

  assign all_hit = min_hit & hour_hit & day_hit;

  alarm_flag_ctl u_flag (
    .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(min_tick_i), .match_i(all_hit),
    .irq_en_i(irq_en_i), .clr_i(flag_clr_i), .flag_o(flag_o), .irq_n_o(irq_n_o));

  // R6
  mismatch_block_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!flag_o && !flag_clr_i && min_tick_i && !alm_min_i[FW-1]
     && alm_min_i[MIN_VW-1:0] != cur_min_i[MIN_VW-1:0]) |=> !flag_o);
endmodule

// File: tb/rtc_alarm_irq_bench.sv
module rtc_alarm_irq_bench;
  localparam int CLK_PERIOD = 10;

  typedef struct packed {
    logic [7:0] cm, ch;
    logic [6:0] cw;
    logic [7:0] cd, am, ah, ad;
    logic       mode;
    logic       exp;
  } vec_t;

  localparam int NV = 11;
  localparam vec_t VECS [NV] = '{
    '{8'h30, 8'h12, 7'h01, 8'h15, 8'h30, 8'h12, 8'h15, 1'b1, 1'b1}, // R2 full match
    '{8'h30, 8'h12, 7'h01, 8'h15, 8'h31, 8'h12, 8'h15, 1'b1, 1'b0}, // R6 minute
    '{8'h30, 8'h12, 7'h01, 8'h15, 8'h30, 8'h13, 8'h15, 1'b1, 1'b0}, // R6 hour
    '{8'h30, 8'h12, 7'h01, 8'h15, 8'h30, 8'h12, 8'h16, 1'b1, 1'b0}, // R6 date
    '{8'h59, 8'h23, 7'h04, 8'h31, 8'h59, 8'h23, 8'h0C, 1'b0, 1'b1}, // R3 mask hit
    '{8'h59, 8'h23, 7'h20, 8'h31, 8'h59, 8'h23, 8'h0C, 1'b0, 1'b0}, // R3 mask miss
    '{8'h00, 8'h00, 7'h01, 8'h01, 8'h00, 8'h00, 8'h00, 1'b0, 1'b0}, // R3 empty mask
    '{8'h45, 8'h12, 7'h01, 8'h15, 8'h80, 8'h12, 8'h15, 1'b1, 1'b1}, // R4 minute off
    '{8'h07, 8'h09, 7'h40, 8'h28, 8'h80, 8'h80, 8'h80, 1'b0, 1'b1}, // R4 all off
    '{8'h10, 8'h08, 7'h10, 8'h0C, 8'h10, 8'h08, 8'h0C, 1'b1, 1'b1}, // R2 date mode
    '{8'h10, 8'h08, 7'h10, 8'h0C, 8'h10, 8'h08, 8'h0C, 1'b0, 1'b0}  // R3 mode selects mask
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic tick = 0, mode = 0, en = 0, clr = 0;
  logic [7:0] cm = 0, ch = 0, cd = 0, am = 0, ah = 0, ad = 0;
  logic [6:0] cw = 0;
  logic flag, irq_n;
  int checks = 0, errors = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rtc_alarm_irq u_rtc_alarm_irq (
    .clk_i(clk), .rst_ni(rst_n), .min_tick_i(tick),
    .cur_min_i(cm), .cur_hour_i(ch), .cur_wday_i(cw), .cur_mday_i(cd),
    .alm_min_i(am), .alm_hour_i(ah), .alm_day_i(ad),
    .day_mode_i(mode), .irq_en_i(en), .flag_clr_i(clr),
    .flag_o(flag), .irq_n_o(irq_n));

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %b expected %b", req, act, exp);
    end
  endtask

  task automatic pulse_tick();
    @(negedge clk) tick = 1;
    @(negedge clk) tick = 0;
  endtask

  task automatic do_clear();
    @(negedge clk) clr = 1;
    @(negedge clk) clr = 0;
  endtask

  task automatic load_match();
    cm = 8'h30; ch = 8'h12; cd = 8'h15; cw = 7'h01;
    am = 8'h30; ah = 8'h12; ad = 8'h15; mode = 1;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 flag", flag, 1'b0);
    chk("R1 irq_n", irq_n, 1'b1);
    rst_n = 1;
    @(negedge clk);
    chk("R1 flag after release", flag, 1'b0);

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      cm = VECS[i].cm; ch = VECS[i].ch; cw = VECS[i].cw; cd = VECS[i].cd;
      am = VECS[i].am; ah = VECS[i].ah; ad = VECS[i].ad; mode = VECS[i].mode;
      en = 1;
      do_clear();
      pulse_tick();
      chk($sformatf("R2/R3/R4/R6 vec %0d flag", i), flag, VECS[i].exp);
      chk($sformatf("R8 vec %0d irq_n", i), irq_n, ~VECS[i].exp);
    end

    // R5: match without tick
    load_match();
    do_clear();
    repeat (3) @(negedge clk);
    chk("R5 no tick", flag, 1'b0);

    // R7: sticky across a non-matching tick
    pulse_tick();
    chk("R7 set", flag, 1'b1);
    am = 8'h31;
    pulse_tick();
    repeat (2) @(negedge clk);
    chk("R7 sticky", flag, 1'b1);

    // R9: enable off releases, back on re-drives
    en = 0;
    @(negedge clk);
    chk("R9 release on enable low", irq_n, 1'b1);
    chk("R7 flag kept", flag, 1'b1);
    en = 1;
    @(negedge clk);
    chk("R9 reassert", irq_n, 1'b0);

    // R7/R9: clear drops flag and releases line
    do_clear();
    chk("R7 clear", flag, 1'b0);
    chk("R9 release on clear", irq_n, 1'b1);

    // R7: simultaneous event and clear
    am = 8'h30;
    pulse_tick();
    chk("R7 set again", flag, 1'b1);
    @(negedge clk) begin tick = 1; clr = 1; end
    @(negedge clk) begin tick = 0; clr = 0; end
    chk("R7 event beats clear", flag, 1'b1);

    // R8: disabled interrupt leaves line released
    en = 0;
    do_clear();
    pulse_tick();
    chk("R8 flag with enable off", flag, 1'b1);
    chk("R8 irq_n with enable off", irq_n, 1'b1);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule